// File: doc/BRIEF.md
# Masked Multiply-Accumulate Status Interrupt Controller

This block turns the arithmetic status flags of a multiply-accumulate unit into an interrupt request for the CPU interrupt controller. Four flags come in as live levels: carry, overflow, extension and limit. Each flag has its own mask bit. One global enable bit gates all four. When a flag that is both unmasked and enabled becomes set, a sticky request flag is raised.

The request flag stays set until software clears it. As long as it is set and the global enable is on, the interrupt line stays asserted. A handler that returns without clearing the flag therefore re-enters at once. Software uses a two-word register port: a control word that holds the enable, and a status word that holds the live flags, the masks and the request flag.

Top module: `mac_irq_ctrl`

## Requirements
- R1: Register address 0 is the control word. Bit 0 is the global enable and is readable and writable. All other bits read as 0.
- R2: Register address 1 is the status word. Bits 3:0 read the live flags in the order carry (bit 0), overflow (bit 1), extension (bit 2) and limit (bit 3). Writes to bits 3:0 are ignored. Bits 7:4 are the masks for the same flags in the same order, and they are readable and writable. Bit 8 is the request flag. Bits 15:9 read as 0.
- R3: The request flag is set at the clock edge where any flag ANDed with its mask and with the global enable goes from 0 to 1. It is visible after that edge.
- R4: A flag whose mask bit is 0, or any flag while the global enable is 0, never sets the request flag.
- R5: Hardware never clears the request flag. Only a status write changes it, and that write loads bit 8 of the written data (0 clears it, 1 sets it).
- R6: The interrupt line equals the request flag ANDed with the global enable, in every cycle.
- R7: A status write that clears the request flag in the same cycle as a qualifying 0-to-1 transition leaves the request flag set.
- R8: A qualifying flag that stays high after software clears the request flag does not set the request flag again.
- R9: After an asynchronous reset, the enable, the masks and the request flag are all 0 and the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_flags | input | 4 | Live flags: carry, overflow, extension, limit (bits 0 to 3) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Two things can land on the request flag in the same clock cycle: a software write that clears it, and a new qualifying flag transition that sets it. The directed part of the bench drops a flag and then raises it again in exactly the cycle that carries a clearing status write, and it expects the flag to stay set. The random phase produces many more such overlaps. It drives random flag patterns and random writes together, and compares the read-back word and the interrupt line after every edge with a bench model built from the requirements.

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl #(
  parameter int NSRC   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   stat_flags,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int MASK_LO = NSRC;
  localparam int REQ_BIT = 2 * NSRC;

  logic            en_q;
  logic [NSRC-1:0] mask_q;
  logic            req_q;
  logic [NSRC-1:0] qual_prev_q;

  logic [NSRC-1:0] qual;
  logic            set_evt;
  logic            wr_ctl;
  logic            wr_stat;

  assign qual    = stat_flags & mask_q & {NSRC{en_q}};
  assign set_evt = |(qual & ~qual_prev_q);
  assign wr_ctl  = reg_wr && !reg_addr;
  assign wr_stat = reg_wr && reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      mask_q      <= '0;
      req_q       <= 1'b0;
      qual_prev_q <= '0;
    end else begin
      qual_prev_q <= qual;
      if (wr_ctl)
        en_q <= reg_wdata[0];
      if (wr_stat)
        mask_q <= reg_wdata[MASK_LO +: NSRC];
      if (set_evt)
        req_q <= 1'b1;
      else if (wr_stat)
        req_q <= reg_wdata[REQ_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr) begin
      reg_rdata[0] = en_q;
    end else begin
      reg_rdata[NSRC-1:0]          = stat_flags;
      reg_rdata[MASK_LO +: NSRC]   = mask_q;
      reg_rdata[REQ_BIT]           = req_q;
    end
  end

  assign irq_o = req_q & en_q;
endmodule

// File: rtl/mac_irq_ctrl_chk.sv
module mac_irq_ctrl_chk #(
  parameter int NSRC   = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   stat_flags,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq_o,
  input logic              en_q,
  input logic [NSRC-1:0]   mask_q,
  input logic              req_q,
  input logic [NSRC-1:0]   qual_prev_q
);
  localparam int REQ_BIT = 2 * NSRC;

  a_r6_irq_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq_o);

  a_r5_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !(reg_wr && reg_addr && !reg_wdata[REQ_BIT])) |=> req_q);

  a_r4_set_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !(reg_wr && reg_addr && reg_wdata[REQ_BIT]) &&
     !(en_q && |(stat_flags & mask_q))) |=> !req_q);

  a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && !reg_wdata[REQ_BIT] && en_q &&
     |(stat_flags & mask_q & ~qual_prev_q)) |=> req_q);
endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_flags(stat_flags), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_o(irq_o),
  .en_q(en_q), .mask_q(mask_q), .req_q(req_q), .qual_prev_q(qual_prev_q)
);

// File: tb/mac_irq_ctrl_test.sv
module mac_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  stat_flags = '0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic       m_en;
  logic [3:0] m_mask;
  logic       m_req;
  logic [3:0] m_prev;

  mac_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .stat_flags(stat_flags), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic a);
    if (!a) return {15'd0, m_en};
    return {7'd0, m_req, m_mask, stat_flags};
  endfunction

  function automatic logic exp_irq();
    return m_req & m_en;
  endfunction

  task automatic model_edge();
    logic [3:0] q;
    logic ev;
    q  = stat_flags & m_mask & {4{m_en}};
    ev = |(q & ~m_prev);
    m_prev = q;
    if (reg_wr && !reg_addr) m_en = reg_wdata[0];
    if (reg_wr && reg_addr) begin
      m_mask = reg_wdata[7:4];
      m_req  = reg_wdata[8];
    end
    if (ev) m_req = 1'b1;
  endtask

  task automatic step(input string req, input logic [3:0] f, input logic wr,
                      input logic a, input logic [15:0] d, input logic ra);
    stat_flags = f; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = ra;
    #1;
    check({req, " irq"}, {15'd0, irq_o}, {15'd0, exp_irq()});
    check({req, " rdata"}, reg_rdata, exp_read(ra));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_mask = 0; m_req = 0; m_prev = 0;
    stat_flags = 4'hF;
    repeat (3) @(negedge clk);
    reg_addr = 1'b0; #1;
    check("R9 reset ctrl", reg_rdata, 16'h0000);
    check("R9 reset irq", {15'd0, irq_o}, 16'h0);
    reg_addr = 1'b1; #1;
    check("R9 reset status", reg_rdata, 16'h000F);
    stat_flags = 4'h0;
    @(negedge clk); rst_n = 1'b1;

    step("R1 enable write", 4'h0, 1, 0, 16'hFFFF, 0);
    check("R1 enable readback", reg_rdata, 16'h0001);
    step("R2 mask carry", 4'h0, 1, 1, 16'h001F, 1);
    check("R2 flag bits ignore writes", reg_rdata, 16'h0010);
    step("R3 carry rises", 4'h1, 0, 0, 16'h0, 1);
    check("R3 request set", reg_rdata, 16'h0111);
    check("R6 irq asserted", {15'd0, irq_o}, 16'h1);
    step("R5 hold", 4'h0, 0, 0, 16'h0, 1);
    check("R5 request sticky", reg_rdata[8], 1'b1);
    step("R8 raise again", 4'h1, 0, 0, 16'h0, 1);
    step("R8 clear while high", 4'h1, 1, 1, 16'h0010, 1);
    step("R8 level held", 4'h1, 0, 0, 16'h0, 1);
    check("R8 no retrigger", reg_rdata[8], 1'b0);
    step("R7 drop", 4'h0, 0, 0, 16'h0, 1);
    step("R7 rise with clear", 4'h1, 1, 1, 16'h0010, 1);
    check("R7 event beats clear", reg_rdata[8], 1'b1);
    step("R4 clear", 4'h0, 1, 1, 16'h0010, 1);
    step("R4 masked overflow", 4'h2, 0, 0, 16'h0, 1);
    check("R4 masked source ignored", reg_rdata[8], 1'b0);
    step("R4 drop", 4'h0, 0, 0, 16'h0, 1);
    step("R4 disable", 4'h0, 1, 0, 16'h0, 1);
    step("R4 disabled carry", 4'h1, 0, 0, 16'h0, 1);
    check("R4 disabled source ignored", reg_rdata[8], 1'b0);
    step("R5 sw set", 4'h0, 1, 1, 16'h0100, 0);
    check("R6 irq low while disabled", {15'd0, irq_o}, 16'h0);
    step("R6 re-enable", 4'h0, 1, 0, 16'h0001, 1);
    check("R6 irq follows enable", {15'd0, irq_o}, 16'h1);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] f;
      logic wr, a, ra;
      logic [15:0] d;
      f  = 4'($urandom_range(0, 15));
      wr = ($urandom_range(0, 3) == 0);
      a  = ($urandom_range(0, 3) != 0);
      d  = 16'($urandom);
      ra = 1'($urandom);
      step("R3 R5 R7 random", f, wr, a, d, ra);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule